// File: doc/BRIEF.md
# Page-mode DRAM fetch controller

This controller connects a CPU core with an 8-bit data bus to a DRAM array of 256 rows by 256 bytes. Each 16-bit request address is cut into a row (upper byte) and a column (lower byte). The row most recently opened stays open with the row strobe held low. A later request into that same 256-byte page therefore costs only a column cycle. Moving to another page costs a precharge cycle and then a row cycle.

DRAM refresh is not spread across instruction fetches. A free-running period timer requests a refresh burst at a fixed interval. During the burst the CPU is stalled and a run of consecutive rows is strobed. A rolling row pointer carries on from the row where the previous burst stopped. A burst destroys the open-row information, so the next access always begins with a row cycle. Requests whose upper byte falls in the external slot range take a slow path instead: one address phase followed by a fixed number of wait cycles.

The timer period and burst length are given in nanoseconds and converted to clock counts using a clock-frequency parameter. The defaults are 30 µs and 4 µs at 250 MHz.

Top module: `pagemode_fetch_ctrl`

## Requirements
- R1: Row cycles drive address bits 15:8 on `dram_addr_o` while `ras_n_o` falls. The column cycle drives bits 7:0 with `cas_n_o` low, and the row latched by the DRAM then equals bits 15:8 of the request.
- R2: If a DRAM request has the same upper byte as the valid open row, no row cycle is issued. `ready_o` rises in the cycle after the request is accepted, so latency is 2 cycles counting the accept cycle.
- R3: A page miss with no valid open row issues one row cycle and then the column cycle (latency 3). A miss while another row is open first spends one precharge cycle with `ras_n_o` high (latency 4).
- R4: Reset clears the open-row valid state, and so does every refresh burst. The first DRAM access after either one performs a row cycle.
- R5: When no access delays it, a refresh burst begins every PERIOD_CYC = CLK_MHZ*REF_PERIOD_NS/1000 cycles.
- R6: `stall_o` stays high for BURST_CYC cycles, where BURST_CYC is CLK_MHZ*REF_BURST_NS/1000 rounded down to even. Each pair of cycles refreshes one row: `ras_n_o` is high in the first cycle and low in the second. A burst therefore strobes BURST_CYC/2 rows, and its first cycle has `ras_n_o` high.
- R7: The refresh row pointer starts at 0 after reset and advances by one per refreshed row. It carries on across bursts and wraps from 255 to 0.
- R8: A request that arrives during a burst gets no `ready_o` while `stall_o` is high. It is accepted in the first cycle after the burst, begins with a row cycle, and completes two cycles after `stall_o` falls.
- R9: A refresh never interrupts an accepted access. If the timer expires during an access, the access finishes with normal latency and `stall_o` rises in the following cycle.
- R10: A request whose upper byte is at least EXT_ROW_BASE (0xC0 by default) uses the slot bus. It has one cycle with `slot_ale_o` high, then SLOW_WAITS cycles, with `ready_o` high in the last of them (latency 2+SLOW_WAITS, default 5). `cas_n_o` stays high throughout, and `rdata_o` returns `slot_rdata_i`.
- R11: A slot access leaves the open DRAM row as it was. The next DRAM access to that page is a hit.
- R12: A write drives `dram_we_n_o` low together with `cas_n_o` in the column cycle. A later read of the same address returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | 8 | Read data, valid with `ready_o` |
| stall_o | output | 1 | Refresh burst in progress |
| ras_n_o | output | 1 | DRAM row strobe, active low |
| cas_n_o | output | 1 | DRAM column strobe, active low |
| dram_we_n_o | output | 1 | DRAM write enable, active low |
| dram_addr_o | output | 8 | Multiplexed row/column address |
| dram_wdata_o | output | 8 | DRAM write data |
| dram_rdata_i | input | 8 | DRAM read data |
| slot_cs_o | output | 1 | Slot bus cycle active |
| slot_ale_o | output | 1 | Slot address phase |
| slot_we_o | output | 1 | Slot write |
| slot_addr_o | output | 16 | Slot address |
| slot_wdata_o | output | 8 | Slot write data |
| slot_rdata_i | input | 8 | Slot read data |

## Verification
Several properties are checked by assertions on every cycle:
- the column strobe only ever appears under an open row strobe, and never during a slot cycle;
- `ready_o` never coincides with a stall;
- a stall only starts after an idle cycle or a completing access;
- the open row is invalid when a burst ends;
- a same-page hit completes in the following cycle.

Other behaviours need the bench's scenarios to show them. These include the exact latencies of the hit, cold-miss, precharge-miss and slot cases, the burst period measured in quiet stretches, the continuity and wrap of the refresh row pointer over many bursts, the service of a request held through a burst, and the data written and read back through a DRAM model.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_ROW   = 3'd2,
      ST_COL   = 3'd3,
      ST_SADR  = 3'd4,
      ST_SWAIT = 3'd5,
      ST_REFR  = 3'd6
   } pmf_state_e;

endpackage

// File: rtl/pmf_refresh_engine.sv
module pmf_refresh_engine #(
   parameter int PERIOD_CYC = 7500,
   parameter int BURST_CYC  = 1000,
   parameter int ROW_BITS   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic                due_o,
   output logic                busy_o,
   output logic                last_o,
   output logic                ras_low_o,
   output logic [ROW_BITS-1:0] row_o
);

   localparam int TW = $clog2(PERIOD_CYC);
   localparam int BW = $clog2(BURST_CYC);

   logic [TW-1:0]       tcnt_q;
   logic [BW-1:0]       bcnt_q;
   logic                tick;
   logic                pend_q;
   logic                busy_q;
   logic [ROW_BITS-1:0] row_q;

   assign tick = (tcnt_q == TW'(PERIOD_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
      end else if (tick) begin
         tcnt_q <= '0;
      end else begin
         tcnt_q <= tcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (start_i) begin
         pend_q <= 1'b0;
      end else if (tick) begin
         pend_q <= 1'b1;
      end
   end

   assign due_o = pend_q | tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         bcnt_q <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         bcnt_q <= '0;
      end else if (busy_q) begin
         bcnt_q <= bcnt_q + 1'b1;
         if (last_o) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o    = busy_q;
   assign last_o    = busy_q && (bcnt_q == BW'(BURST_CYC - 1));
   assign ras_low_o = busy_q && bcnt_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (busy_q && bcnt_q[0]) begin
         row_q <= row_q + 1'b1;
      end
   end

   assign row_o = row_q;

   assert_start_busy_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o)
      else $error("burst did not begin after start");

   assert_burst_even_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(ras_low_o))
      else $error("burst ended inside a row pair");

endmodule

// File: rtl/pmf_open_row.sv
module pmf_open_row #(
   parameter int ROW_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                kill_i,
   input  logic [ROW_BITS-1:0] row_i,
   output logic                valid_o,
   output logic                hit_o
);

   logic                valid_q;
   logic [ROW_BITS-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         row_q   <= '0;
      end else if (kill_i) begin
         valid_q <= 1'b0;
      end else if (load_i) begin
         valid_q <= 1'b1;
         row_q   <= row_i;
      end
   end

   assign valid_o = valid_q;
   assign hit_o   = valid_q && (row_q == row_i);

   assert_kill_clears_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |=> !valid_o)
      else $error("open row survived a refresh");

endmodule

// File: rtl/pmf_sequencer.sv
module pmf_sequencer
   import pmf_pkg::*;
#(
   parameter int SLOW_WAITS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       ext_i,
   input  logic       hit_i,
   input  logic       row_valid_i,
   input  logic       ref_due_i,
   input  logic       ref_last_i,
   output pmf_state_e state_o,
   output logic       ref_start_o,
   output logic       row_load_o,
   output logic       ready_o
);

   localparam int WCW = (SLOW_WAITS > 1) ? $clog2(SLOW_WAITS) : 1;

   pmf_state_e state_q;
   pmf_state_e state_d;
   logic       wait_done;

   generate
      if (SLOW_WAITS == 1) begin : g_single_wait
         assign wait_done = 1'b1;
      end else begin : g_wait_count
         logic [WCW-1:0] wcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wcnt_q <= '0;
            end else if (state_q != ST_SWAIT) begin
               wcnt_q <= '0;
            end else if (!wait_done) begin
               wcnt_q <= wcnt_q + 1'b1;
            end
         end
         assign wait_done = (wcnt_q == WCW'(SLOW_WAITS - 1));
      end
   endgenerate

   always_comb begin
      state_d     = state_q;
      ref_start_o = 1'b0;
      ready_o     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (ref_due_i) begin
               state_d     = ST_REFR;
               ref_start_o = 1'b1;
            end else if (req_i) begin
               if (ext_i)            state_d = ST_SADR;
               else if (hit_i)       state_d = ST_COL;
               else if (row_valid_i) state_d = ST_PRE;
               else                  state_d = ST_ROW;
            end
         end
         ST_PRE:  state_d = ST_ROW;
         ST_ROW:  state_d = ST_COL;
         ST_COL: begin
            ready_o = 1'b1;
            if (ref_due_i) begin
               state_d     = ST_REFR;
               ref_start_o = 1'b1;
            end else begin
               state_d = ST_IDLE;
            end
         end
         ST_SADR: state_d = ST_SWAIT;
         ST_SWAIT: begin
            if (wait_done) begin
               ready_o = 1'b1;
               if (ref_due_i) begin
                  state_d     = ST_REFR;
                  ref_start_o = 1'b1;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_REFR: begin
            if (ref_last_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o    = state_q;
   assign row_load_o = (state_q == ST_ROW);

   assert_hit_next_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_IDLE && req_i && hit_i && !ext_i && !ref_due_i) |=> ready_o)
      else $error("page hit did not complete in one column cycle");

endmodule

// File: rtl/pagemode_fetch_ctrl.sv
module pagemode_fetch_ctrl
   import pmf_pkg::*;
#(
   parameter int CLK_MHZ       = 250,
   parameter int REF_PERIOD_NS = 30000,
   parameter int REF_BURST_NS  = 4000,
   parameter int ROW_BITS      = 8,
   parameter int PAGE_BITS     = 8,
   parameter int DATA_W        = 8,
   parameter int SLOW_WAITS    = 3,
   parameter int EXT_ROW_BASE  = 192
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_i,
   input  logic                          we_i,
   input  logic [ROW_BITS+PAGE_BITS-1:0] addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   output logic                          ready_o,
   output logic [DATA_W-1:0]             rdata_o,
   output logic                          stall_o,
   output logic                          ras_n_o,
   output logic                          cas_n_o,
   output logic                          dram_we_n_o,
   output logic [PAGE_BITS-1:0]          dram_addr_o,
   output logic [DATA_W-1:0]             dram_wdata_o,
   input  logic [DATA_W-1:0]             dram_rdata_i,
   output logic                          slot_cs_o,
   output logic                          slot_ale_o,
   output logic                          slot_we_o,
   output logic [ROW_BITS+PAGE_BITS-1:0] slot_addr_o,
   output logic [DATA_W-1:0]             slot_wdata_o,
   input  logic [DATA_W-1:0]             slot_rdata_i
);

   localparam int ADDR_W     = ROW_BITS + PAGE_BITS;
   localparam int PERIOD_CYC = CLK_MHZ * REF_PERIOD_NS / 1000;
   localparam int BURST_CYC  = ((CLK_MHZ * REF_BURST_NS / 1000) / 2) * 2;

   generate
      if (ROW_BITS != PAGE_BITS) begin : g_bad_split
         $error("row and column widths must match the shared address pins");
      end
      if (BURST_CYC < 2) begin : g_bad_burst
         $error("refresh burst shorter than one row");
      end
      if (PERIOD_CYC <= BURST_CYC + 8) begin : g_bad_period
         $error("refresh period must exceed the burst length");
      end
      if (SLOW_WAITS < 1) begin : g_bad_waits
         $error("slot path needs at least one wait cycle");
      end
      if (EXT_ROW_BASE < 1 || EXT_ROW_BASE >= (1 << ROW_BITS)) begin : g_bad_base
         $error("slot base must leave both regions non-empty");
      end
   endgenerate

   logic [ROW_BITS-1:0]  req_row;
   logic [PAGE_BITS-1:0] req_col;
   logic                 is_ext;
   pmf_state_e           state;
   logic                 ref_start, ref_due, ref_busy, ref_last, ref_ras_low;
   logic [ROW_BITS-1:0]  ref_row;
   logic                 row_valid, row_hit, row_load;
   logic                 seq_ready;

   assign req_row = addr_i[ADDR_W-1 -: ROW_BITS];
   assign req_col = addr_i[PAGE_BITS-1:0];
   assign is_ext  = (req_row >= ROW_BITS'(EXT_ROW_BASE));

   pmf_refresh_engine #(
      .PERIOD_CYC (PERIOD_CYC),
      .BURST_CYC  (BURST_CYC),
      .ROW_BITS   (ROW_BITS)
   ) refresh_u (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (ref_start),
      .due_o     (ref_due),
      .busy_o    (ref_busy),
      .last_o    (ref_last),
      .ras_low_o (ref_ras_low),
      .row_o     (ref_row)
   );

   pmf_open_row #(
      .ROW_BITS (ROW_BITS)
   ) open_row_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (row_load),
      .kill_i  (ref_start),
      .row_i   (req_row),
      .valid_o (row_valid),
      .hit_o   (row_hit)
   );

   pmf_sequencer #(
      .SLOW_WAITS (SLOW_WAITS)
   ) seq_u (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .ext_i       (is_ext),
      .hit_i       (row_hit),
      .row_valid_i (row_valid),
      .ref_due_i   (ref_due),
      .ref_last_i  (ref_last),
      .state_o     (state),
      .ref_start_o (ref_start),
      .row_load_o  (row_load),
      .ready_o     (seq_ready)
   );

   always_comb begin
      unique case (state)
         ST_REFR:        ras_n_o = ~ref_ras_low;
         ST_PRE:         ras_n_o = 1'b1;
         ST_ROW, ST_COL: ras_n_o = 1'b0;
         default:        ras_n_o = ~row_valid;
      endcase
   end

   always_comb begin
      unique case (state)
         ST_ROW:  dram_addr_o = req_row;
         ST_COL:  dram_addr_o = req_col;
         ST_REFR: dram_addr_o = ref_row;
         default: dram_addr_o = '0;
      endcase
   end

   always_comb begin
      unique case (state)
         ST_COL:   rdata_o = dram_rdata_i;
         ST_SWAIT: rdata_o = slot_rdata_i;
         default:  rdata_o = '0;
      endcase
   end

   assign cas_n_o      = (state != ST_COL);
   assign dram_we_n_o  = !((state == ST_COL) && we_i);
   assign dram_wdata_o = wdata_i;
   assign ready_o      = seq_ready;
   assign stall_o      = ref_busy;

   assign slot_cs_o    = (state == ST_SADR) || (state == ST_SWAIT);
   assign slot_ale_o   = (state == ST_SADR);
   assign slot_we_o    = slot_cs_o && we_i;
   assign slot_addr_o  = addr_i;
   assign slot_wdata_o = wdata_i;

   assert_cas_under_ras_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n_o |-> !ras_n_o)
      else $error("column strobe without open row");

   assert_no_ready_in_stall_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> !ready_o)
      else $error("access completed during refresh");

   assert_stall_after_done_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_o) |-> ($past(ready_o) || $past(state == ST_IDLE)))
      else $error("refresh cut into an access");

   assert_row_dead_after_burst_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall_o) |-> !row_valid)
      else $error("open row still valid after refresh");

   assert_slot_no_cas_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      slot_cs_o |-> cas_n_o)
      else $error("column strobe during slot cycle");

endmodule

// File: tb/pagemode_fetch_ctrl_tb_top.sv
module pagemode_fetch_ctrl_tb_top;

   localparam int PERIOD = 200;
   localparam int BURST  = 20;
   localparam int WAITS  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        ready, stall, ras_n, cas_n, dram_we_n;
   logic [7:0]  rdata, dram_addr, dram_wdata, dram_rdata;
   logic        slot_cs, slot_ale, slot_we;
   logic [15:0] slot_addr;
   logic [7:0]  slot_wdata, slot_rdata;

   always #2 clk = ~clk;

   pagemode_fetch_ctrl #(
      .CLK_MHZ       (250),
      .REF_PERIOD_NS (800),
      .REF_BURST_NS  (80),
      .SLOW_WAITS    (WAITS)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .we_i         (we),
      .addr_i       (addr),
      .wdata_i      (wdata),
      .ready_o      (ready),
      .rdata_o      (rdata),
      .stall_o      (stall),
      .ras_n_o      (ras_n),
      .cas_n_o      (cas_n),
      .dram_we_n_o  (dram_we_n),
      .dram_addr_o  (dram_addr),
      .dram_wdata_o (dram_wdata),
      .dram_rdata_i (dram_rdata),
      .slot_cs_o    (slot_cs),
      .slot_ale_o   (slot_ale),
      .slot_we_o    (slot_we),
      .slot_addr_o  (slot_addr),
      .slot_wdata_o (slot_wdata),
      .slot_rdata_i (slot_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // DRAM and slot device models, shadow of expected contents
   logic [7:0] mem    [0:4095];
   logic [7:0] shadow [0:4095];
   logic [7:0] cur_row = '0;

   initial begin
      for (int i = 0; i < 4096; i++) begin
         mem[i]    = 8'(i * 13 + 7);
         shadow[i] = 8'(i * 13 + 7);
      end
   end

   assign dram_rdata = mem[{cur_row[3:0], dram_addr}];
   assign slot_rdata = slot_addr[7:0] ^ slot_addr[15:8];

   // Monitor state
   int  cyc = 0;
   int  acc_rows = 0;
   int  ale_cnt = 0;
   int  bursts_done = 0;
   int  stall_run = 0;
   int  burst_rows = 0;
   int  exp_ref_row = 0;
   int  fall_cyc = -1000;
   int  last_rise = -1;
   int  spacing_checks = 0;
   bit  wrap_seen = 0;
   bit  prev_ras_n = 1, prev_stall = 0, prev_req = 0, prev2_req = 0, prev_ready = 0;
   bit  req_since_rise = 0, clean_prev = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!ras_n && prev_ras_n) begin
            cur_row <= dram_addr;
            if (stall) begin
               burst_rows++;
               chk(dram_addr == 8'(exp_ref_row), "R7 refresh row", dram_addr, exp_ref_row);
               if (exp_ref_row == 255) wrap_seen = 1;
               exp_ref_row = (exp_ref_row + 1) % 256;
            end else begin
               acc_rows++;
            end
         end
         if (!cas_n) begin
            if (req) begin
               chk(cur_row == addr[15:8] && dram_addr == addr[7:0], "R1 row/col split",
                   {cur_row, dram_addr}, addr);
            end
            if (!dram_we_n) mem[{cur_row[3:0], dram_addr}] <= dram_wdata;
         end
         if (slot_cs && !cas_n) chk(0, "R10 cas during slot", 1, 0);
         if (slot_ale) ale_cnt++;
         if (stall && ready) chk(0, "R8 ready during stall", 1, 0);
         if (req) req_since_rise = 1;
         if (stall && !prev_stall) begin
            chk(ras_n == 1'b1, "R6 first burst cycle ras high", ras_n, 1);
            if (prev_req && prev2_req && !prev_ready) chk(0, "R9 refresh cut access", 1, 0);
            if (last_rise >= 0 && clean_prev && !req_since_rise) begin
               spacing_checks++;
               chk(cyc - last_rise == PERIOD, "R5 burst spacing", cyc - last_rise, PERIOD);
            end
            clean_prev = !req_since_rise;
            req_since_rise = req;
            last_rise = cyc;
            stall_run = 0;
            burst_rows = 0;
         end
         if (stall) stall_run++;
         if (!stall && prev_stall) begin
            fall_cyc = cyc;
            bursts_done++;
            chk(stall_run == BURST, "R6 burst length", stall_run, BURST);
            chk(burst_rows == BURST / 2, "R6 rows per burst", burst_rows, BURST / 2);
         end
         prev2_req  = prev_req;
         prev_req   = req;
         prev_ready = ready;
         prev_stall = stall;
         prev_ras_n = ras_n;
      end
   end

   task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                         input int exp_lat, input int exp_rows, input string tag);
      int lat = 0;
      int rows0;
      int ale0;
      bit stalled = 0;
      logic [7:0] got = '0;
      bit ext = (a[15:8] >= 8'hC0);
      @(posedge clk); #1;
      req = 1; we = w; addr = a; wdata = d;
      rows0 = acc_rows;
      ale0 = ale_cnt;
      forever begin
         @(negedge clk);
         lat++;
         if (stall) stalled = 1;
         if (ready) begin
            got = rdata;
            break;
         end
      end
      @(posedge clk); #1;
      req = 0; we = 0;
      if (!stalled) begin
         chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
         chk(acc_rows - rows0 == exp_rows, {tag, " row cycles"}, acc_rows - rows0, exp_rows);
      end
      if (ext) begin
         chk(ale_cnt - ale0 == 1, "R10 one address phase", ale_cnt - ale0, 1);
         if (!w) chk(got == (a[7:0] ^ a[15:8]), "R10 slot data", got, a[7:0] ^ a[15:8]);
      end else if (w) begin
         shadow[{a[11:8], a[7:0]}] = d;
      end else begin
         chk(got == shadow[{a[11:8], a[7:0]}], {tag, " read data"}, got,
             shadow[{a[11:8], a[7:0]}]);
      end
   endtask

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         report();
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(ready == 0, "R4 reset ready", ready, 0);
      chk(stall == 0, "R4 reset stall", stall, 0);
      chk(ras_n == 1 && cas_n == 1, "R4 reset strobes", {ras_n, cas_n}, 3);
      chk(slot_cs == 0, "R4 reset slot", slot_cs, 0);
      @(posedge clk); #1 rst_n = 1;

      access(0, 16'h1234, 8'h00, 3, 1, "R4 first after reset");
      access(0, 16'h1235, 8'h00, 2, 0, "R2 page hit");
      access(1, 16'h12F0, 8'hA5, 2, 0, "R12 write hit");
      access(0, 16'h12F0, 8'h00, 2, 0, "R12 readback");
      access(0, 16'h1300, 8'h00, 4, 1, "R3 miss with open row");
      access(0, 16'hC012, 8'h00, 2 + WAITS, 0, "R10 slot read");
      access(0, 16'h1301, 8'h00, 2, 0, "R11 hit after slot");

      begin
         int tgt = bursts_done + 1;
         while (bursts_done < tgt) @(negedge clk);
      end
      access(0, 16'h1302, 8'h00, 3, 1, "R4 first after burst");
      access(1, 16'h1310, 8'h3C, 2, 0, "R12 write");
      access(0, 16'h1310, 8'h00, 2, 0, "R12 read");

      // R8: request raised while a burst is running
      begin
         int rows0;
         while (!stall) @(negedge clk);
         @(posedge clk); #1;
         req = 1; we = 0; addr = 16'h1420;
         rows0 = acc_rows;
         forever begin
            @(negedge clk);
            if (ready) break;
         end
         chk(cyc == fall_cyc + 2, "R8 service after burst", cyc - fall_cyc, 2);
         chk(rdata == shadow[12'h420], "R8 data", rdata, shadow[12'h420]);
         @(posedge clk); #1 req = 0;
         chk(acc_rows - rows0 == 1, "R8 row cycle", acc_rows - rows0, 1);
      end

      // R9: dense slot traffic across timer expiries
      for (int k = 0; k < 45; k++) begin
         access(0, 16'hC100 + 16'(k), 8'h00, 2 + WAITS, 0, "R9 access around refresh");
      end

      while (bursts_done < 28) @(negedge clk);
      chk(wrap_seen, "R7 row pointer wrap", wrap_seen, 1);
      chk(spacing_checks > 0, "R5 spacing observed", spacing_checks, 1);
      access(0, 16'h2005, 8'h00, 3, 1, "R4 first after idle bursts");

      done = 1;
      report();
      $finish;
   end

endmodule